// File: doc/BRIEF.md
# Oscillator Settling Wait Timer

This block keeps a crystal oscillator clock from being used before it has settled. Once the oscillator is switched on, or once a low-power stop state is left while the oscillator stays switched on, a counter starts at zero. It advances by one on each cycle in which an oscillator edge is reported on `osc_tick`. A 3-bit wait code chooses how many edges must be seen before the clock is reported as usable. The wait lengths are powers of two but are not evenly spaced: 2^12, 2^14 and 2^16 are not among them.

The block has an 8-bit configuration register that software can read and write, and only the low three bits of it hold state. An 8-bit progress vector shows which of the eight possible wait lengths the count has already covered. This progress never runs past the length chosen for the current count. A `clk_ready` flag rises when the chosen length is reached. The counter saturates at that length, so the flag stays high until the oscillator is switched off or the stop state is entered again. The wait code is captured when a count starts, so software has to program it before switching the oscillator on.

Top module: `osc_settle_timer`

## Requirements
- R1: The wait code selects a length in osc_tick cycles: 0→256, 1→512, 2→1024, 3→2048, 4→8192, 5→32768, 6→131072, 7→262144.
- R2: cfg_rdata returns the stored code in bits 2:0. Bits 7:3 always read 0, and the values written to bits 7:3 have no effect.
- R3: After reset the register reads 8'h07, clk_ready is 0 and settle_status is 0.
- R4: The count rises only on clock edges where osc_tick is 1 and a count is already running. Ticks seen while the oscillator is off, or on the start edge itself, are not counted.
- R5: A count starts, from zero, at the first clock edge at which osc_en is 1 and stop_mode is 0 after a cycle where that did not hold. This covers both osc_en rising and stop_mode falling. The start captures the stored wait code.
- R6: settle_status bit i is 1 when both of these hold: the count has reached the length of code i, and i is not above the captured code. All other bits are 0.
- R7: clk_ready is 1 exactly when the count equals the length of the captured code, with a count running.
- R8: One clock edge with osc_en at 0 or stop_mode at 1 clears the count, settle_status and clk_ready.
- R9: A write made while a count runs, or on the same edge as a start, is stored and readable at once. It only changes the wait length at the next start.
- R10: Once the length is reached, further ticks change neither clk_ready nor settle_status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator switched on |
| stop_mode | input | 1 | Low-power stop state active |
| osc_tick | input | 1 | An oscillator edge arrived this cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| settle_status | output | 8 | Per-length progress bits |
| clk_ready | output | 1 | Oscillator settled |

## Verification
Two events can land on the same clock edge: a register write and a count start, when osc_en rises in the very cycle that cfg_we is high. The bench provokes this by raising both at one negative edge with a new code. It expects the new code to read back at once while the wait length still follows the old code: clk_ready must rise after 256 ticks, not 512. A later start must then use the newest code written.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;
  localparam int SEL_W  = 3;
  localparam int NCODES = 1 << SEL_W;
  localparam int CNT_W  = 19;

  // Exponent of the wait length for each code; 12, 14 and 16 are skipped.
  function automatic logic [4:0] wait_exp(input logic [SEL_W-1:0] code);
    logic [4:0] e;
    case (code)
      3'd4:    e = 5'd13;
      3'd5:    e = 5'd15;
      3'd6:    e = 5'd17;
      3'd7:    e = 5'd18;
      default: e = 5'd8 + {2'b00, code};
    endcase
    return e;
  endfunction

  function automatic logic [CNT_W-1:0] wait_len(input logic [SEL_W-1:0] code);
    logic [CNT_W-1:0] one;
    one = {{(CNT_W-1){1'b0}}, 1'b1};
    return one << wait_exp(code);
  endfunction
endpackage

// File: rtl/osc_settle_cfg.sv
module osc_settle_cfg
  import osc_settle_pkg::*;
#(
  parameter int REG_W = 8,
  parameter logic [SEL_W-1:0] RST_CODE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic [SEL_W-1:0] sel_code
);
  localparam int PAD_W = REG_W - SEL_W;

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= RST_CODE;
    else if (cfg_we) sel_q <= cfg_wdata[SEL_W-1:0];
  end

  assign sel_code  = sel_q;
  assign cfg_rdata = {{PAD_W{1'b0}}, sel_q};

  // R9: a write is visible on the next cycle whatever the counter is doing
  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (sel_code == $past(cfg_wdata[SEL_W-1:0])));
endmodule

// File: rtl/osc_settle_count.sv
module osc_settle_count
  import osc_settle_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             stop_mode,
  input  logic             osc_tick,
  input  logic [SEL_W-1:0] sel_in,
  output logic [CNT_W-1:0] cnt,
  output logic [SEL_W-1:0] sel_act,
  output logic             active,
  output logic             at_limit
);
  logic             go;
  logic             start_evt;
  logic             advance;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_act_q;
  logic             active_q;

  assign go        = osc_en & ~stop_mode;
  assign start_evt = go & ~active_q;
  assign at_limit  = (cnt_q == wait_len(sel_act_q));
  assign advance   = active_q & go & osc_tick & ~at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sel_act_q <= '1;
      active_q  <= 1'b0;
    end else if (!go) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_evt) begin
      cnt_q     <= '0;
      sel_act_q <= sel_in;
      active_q  <= 1'b1;
    end else if (advance) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt     = cnt_q;
  assign sel_act = sel_act_q;
  assign active  = active_q;

  // R8: leaving the running condition wipes the count
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (cnt == '0 && !active));
  // R5: a start always begins at zero
  assert_start_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (cnt == '0 && active));
  // R4: no tick, no progress
  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && go && !osc_tick) |=> $stable(cnt));
  // R10: once reached, the limit is kept while running
  assert_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && go && at_limit) |=> at_limit);
  // R9: the captured code does not follow register writes mid-count
  assert_code_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && go) |=> $stable(sel_act));
endmodule

// File: rtl/osc_settle_decode.sv
module osc_settle_decode
  import osc_settle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [SEL_W-1:0]  sel_act,
  input  logic              active,
  input  logic              at_limit,
  output logic [NCODES-1:0] status,
  output logic              ready
);
  for (genvar i = 0; i < NCODES; i++) begin : g_thr
    assign status[i] = active && (SEL_W'(i) <= sel_act) &&
                       (cnt >= wait_len(SEL_W'(i)));
  end

  assign ready = active & at_limit;

  // R6/R7: at the limit, exactly the bits up to the captured code are set
  assert_ready_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ($countones(status) == 32'(sel_act) + 1));
  // R6: the bit of the captured code is never set ahead of ready
  assert_top_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status[sel_act] |-> ready);
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer
  import osc_settle_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             stop_mode,
  input  logic             osc_tick,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic [7:0]       settle_status,
  output logic             clk_ready
);
  logic [SEL_W-1:0]  sel_code;
  logic [SEL_W-1:0]  sel_act;
  logic [CNT_W-1:0]  cnt;
  logic              active;
  logic              at_limit;
  logic [NCODES-1:0] status_w;

  osc_settle_cfg #(.REG_W(REG_W), .RST_CODE(3'd7)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sel_code(sel_code)
  );

  osc_settle_count u_count (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop_mode(stop_mode),
    .osc_tick(osc_tick), .sel_in(sel_code), .cnt(cnt), .sel_act(sel_act),
    .active(active), .at_limit(at_limit)
  );

  osc_settle_decode u_decode (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .sel_act(sel_act), .active(active),
    .at_limit(at_limit), .status(status_w), .ready(clk_ready)
  );

  assign settle_status = status_w;
endmodule

// File: tb/osc_settle_timer_tb.sv
`timescale 1ns/1ps
module osc_settle_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0, stop_mode = 1'b0, osc_tick = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata, settle_status;
  logic       clk_ready;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  osc_settle_timer u_dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop_mode(stop_mode),
    .osc_tick(osc_tick), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .settle_status(settle_status), .clk_ready(clk_ready)
  );

  function automatic int len_of(int code);
    case (code)
      0: return 256;    1: return 512;     2: return 1024;    3: return 2048;
      4: return 8192;   5: return 32768;   6: return 131072;  default: return 262144;
    endcase
  endfunction

  function automatic logic [7:0] exp_st(int c, int code);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < 8; i++) if (i <= code && c >= len_of(i)) s[i] = 1'b1;
    return s;
  endfunction

  task automatic chk(string req, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_out(string req, logic rdy, logic [7:0] st);
    chk(req, {clk_ready, settle_status}, {rdy, st});
  endtask

  task automatic wr(logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic off();
    osc_en = 1'b0; @(negedge clk);
  endtask

  // raises osc_en at a negedge; after the return, cnt = n
  task automatic start_and_run(int n);
    osc_en = 1'b1; osc_tick = 1'b1;
    @(posedge clk);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R3 reset", {1'b0, cfg_rdata}, 9'h007);
    chk_out("R3 reset outputs", 1'b0, 8'h00);
  endtask

  task automatic t_regbits();
    wr(8'hFF); chk("R2 upper bits", {1'b0, cfg_rdata}, 9'h007);
    wr(8'hA2); chk("R2 write a2", {1'b0, cfg_rdata}, 9'h002);
  endtask

  task automatic t_code(int code);
    off(); wr(8'(code));
    start_and_run(len_of(code) - 1);
    chk_out("R1 R6 before limit", 1'b0, exp_st(len_of(code) - 1, code));
    @(negedge clk);
    chk_out("R1 R7 at limit", 1'b1, exp_st(len_of(code), code));
    repeat (20) @(negedge clk);
    chk_out("R10 saturated", 1'b1, exp_st(len_of(code), code));
    osc_en = 1'b0; @(negedge clk);
    chk_out("R8 disable clears", 1'b0, 8'h00);
  endtask

  task automatic t_gap();
    off(); wr(8'h00);
    osc_tick = 1'b1; repeat (50) @(negedge clk);
    chk_out("R4 no count while off", 1'b0, 8'h00);
    osc_en = 1'b1; @(negedge clk);
    for (int k = 1; k <= 256; k++) begin
      osc_tick = 1'b1; @(negedge clk);
      osc_tick = 1'b0; @(negedge clk);
      if (k == 255) chk_out("R4 gapped ticks 255", 1'b0, 8'h00);
    end
    chk_out("R4 gapped ticks 256", 1'b1, 8'h01);
    repeat (30) @(negedge clk);
    chk_out("R4 R10 idle hold", 1'b1, 8'h01);
    osc_tick = 1'b1;
  endtask

  task automatic t_collide();
    off(); wr(8'h00);
    cfg_we = 1'b1; cfg_wdata = 8'h01;
    start_and_run(255);
    cfg_we = 1'b0;
    chk("R9 new code readable", {1'b0, cfg_rdata}, 9'h001);
    chk_out("R9 old length 255", 1'b0, 8'h00);
    @(negedge clk);
    chk_out("R9 old length 256", 1'b1, 8'h01);
    wr(8'h03);
    repeat (5) @(negedge clk);
    chk_out("R9 mid-run write ignored", 1'b1, 8'h01);
    off();
    start_and_run(2047);
    chk_out("R9 next start 2047", 1'b0, exp_st(2047, 3));
    @(negedge clk);
    chk_out("R9 next start 2048", 1'b1, exp_st(2048, 3));
  endtask

  task automatic t_stop();
    off(); wr(8'h02);
    start_and_run(1024);
    chk_out("R5 ready before stop", 1'b1, 8'h07);
    stop_mode = 1'b1; @(negedge clk);
    chk_out("R8 stop clears", 1'b0, 8'h00);
    repeat (100) @(negedge clk);
    chk_out("R8 stays clear in stop", 1'b0, 8'h00);
    stop_mode = 1'b0;
    @(posedge clk);
    repeat (600) @(posedge clk);
    @(negedge clk);
    chk_out("R5 restart partial", 1'b0, exp_st(600, 2));
    repeat (424) @(negedge clk);
    chk_out("R5 restart ready", 1'b1, 8'h07);
  endtask

  task automatic t_code7();
    off(); wr(8'h07);
    start_and_run(2048);
    chk_out("R1 R6 code7 partial", 1'b0, exp_st(2048, 7));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regbits();
    for (int c = 0; c <= 5; c++) t_code(c);
    t_gap();
    t_collide();
    t_stop();
    t_code7();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule